// File: doc/BRIEF.md
# Picture-in-Picture Display Compositor

This block places a thumbnail window on top of a full-resolution video frame while the frame is streamed out toward a display. It watches the display-side active-video, horizontal-sync and vertical-sync strobes and keeps its own column and line position from them. It asks two first-word-fall-through pixel queues for data. One queue holds the full frame and the other holds the downscaled thumbnail. Alongside each request it gives the linear word address of that pixel in its frame-store region.

On every active pixel the block forwards one of two values, chosen only by its own display position. Inside the window it forwards the thumbnail pixel, and everywhere else the full-frame pixel. It registers the result together with the three strobes, so the output stays aligned with its timing. The stored frame is never overwritten. If a pixel inside the window finds the thumbnail queue empty, the block falls back to the full-frame pixel and latches an underflow flag.

Defaults are a 1920 x 1080 active frame of 24-bit RGB (8 bits per channel) at 148.5 MHz pixel rate. The default window is 480 x 270, placed with its top-left corner at line 50, column 1240. The full frame is stored from word 0. The thumbnail is stored from word 2000 x 1080.

Top module: `pip_compositor`

## Requirements
- R1: While reset is high and on the first cycle after it, pix_out, de_out, hs_out, vs_out and thumb_underflow are all 0.
- R2: frame_pop equals vid_de in the same cycle. The full-frame queue is popped on every active pixel, including pixels inside the window.
- R3: thumb_pop is 1 exactly when vid_de is 1, the current pixel lies inside the window, and thumb_empty is 0. The window covers columns WIN_X to WIN_X+WIN_W-1 and lines WIN_Y to WIN_Y+WIN_H-1. With no underflow there are exactly WIN_W x WIN_H pops per frame.
- R4: One cycle after an active pixel, pix_out shows the thumbnail word for a popped window pixel and the full-frame word otherwise. It is 0 one cycle after a cycle with vid_de low. Bits [23:16], [15:8] and [7:0] are red, green and blue.
- R5: de_out, hs_out and vs_out equal vid_de, vid_hs and vid_vs delayed by one cycle.
- R6: The column of the k-th active pixel of a line is k, counting from 0, whatever the horizontal blanking length. The line number rises by one after each active line and returns to 0 on a rising edge of vid_vs.
- R7: While vid_de is 1, frame_addr equals line x H_ACT + column.
- R8: For a window pixel, thumb_addr equals THUMB_BASE + (line - WIN_Y) x WIN_W + (column - WIN_X).
- R9: A window pixel that finds thumb_empty high is sent out as the full-frame word. thumb_underflow becomes 1 on the next cycle and stays 1 until reset. thumb_empty outside the window has no effect on the flag.
- R10: The thumbnail address restarts at THUMB_BASE after every rising edge of vid_vs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_de | input | 1 | Display-side active-video strobe |
| vid_hs | input | 1 | Display-side horizontal sync |
| vid_vs | input | 1 | Display-side vertical sync |
| frame_pix | input | 24 | Head word of the full-frame queue |
| thumb_pix | input | 24 | Head word of the thumbnail queue |
| thumb_empty | input | 1 | Thumbnail queue has no data |
| frame_pop | output | 1 | Pop request to the full-frame queue |
| thumb_pop | output | 1 | Pop request to the thumbnail queue |
| frame_addr | output | ADDR_W | Word address of the current full-frame pixel |
| thumb_addr | output | ADDR_W | Word address of the current thumbnail pixel |
| pix_out | output | 24 | Composited RGB pixel |
| de_out | output | 1 | Delayed active-video strobe |
| hs_out | output | 1 | Delayed horizontal sync |
| vs_out | output | 1 | Delayed vertical sync |
| thumb_underflow | output | 1 | Sticky thumbnail-starvation flag |

## Verification
The hardest case to reach is a thumbnail queue that runs dry at one chosen pixel in the middle of the window. Around that case, the flag must stay clear while thumb_empty is held high outside the window, and it must stay latched through a later clean frame. The bench runs scaled-down frames so the window is small. It lowers thumb_empty everywhere inside the window except at one selected thumbnail index, and holds it high at every pixel outside the window. Each frame in the scenario table also uses a different horizontal blanking length, so a column counter that does not restart at the start of each line shows up as wrong addresses.

// File: rtl/pip_pkg.sv
package pip_pkg;

    localparam int PIX_W = 24;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    typedef struct packed {
        logic de;
        logic hs;
        logic vs;
    } sync_t;

    function automatic logic in_span(input int pos, input int lo, input int len);
        return (pos >= lo) && (pos < lo + len);
    endfunction

endpackage

// File: rtl/pip_pos_tracker.sv
module pip_pos_tracker
    import pip_pkg::*;
#(
    parameter int H_ACT = 1920,
    parameter int V_ACT = 1080,
    parameter int WIN_X = 1240,
    parameter int WIN_Y = 50,
    parameter int WIN_W = 480,
    parameter int WIN_H = 270,
    localparam int COL_W  = $clog2(H_ACT + 1),
    localparam int LINE_W = $clog2(V_ACT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  sync_t             sync_in,
    output logic              frame_start,
    output logic [COL_W-1:0]  col,
    output logic [LINE_W-1:0] line,
    output logic              in_win
);

    logic [COL_W-1:0]  col_q;
    logic [LINE_W-1:0] line_q;
    logic              de_q;
    logic              vs_q;

    assign frame_start = sync_in.vs && !vs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q  <= '0;
            line_q <= '0;
            de_q   <= 1'b0;
            vs_q   <= 1'b0;
        end else begin
            de_q <= sync_in.de;
            vs_q <= sync_in.vs;
            col_q <= sync_in.de ? col_q + COL_W'(1) : '0;
            if (frame_start)
                line_q <= '0;
            else if (de_q && !sync_in.de)
                line_q <= line_q + LINE_W'(1);
        end
    end

    assign col    = col_q;
    assign line   = line_q;
    assign in_win = sync_in.de
                 && in_span(int'(col_q), WIN_X, WIN_W)
                 && in_span(int'(line_q), WIN_Y, WIN_H);

endmodule

// File: rtl/pip_addr_gen.sv
module pip_addr_gen
    import pip_pkg::*;
#(
    parameter int ADDR_W     = 22,
    parameter int THUMB_BASE = 2000 * 1080
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              active,
    input  logic              in_win,
    output logic [ADDR_W-1:0] frame_addr,
    output logic [ADDR_W-1:0] thumb_addr
);

    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(THUMB_BASE);

    logic [ADDR_W-1:0] fa_q;
    logic [ADDR_W-1:0] ta_q;

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            fa_q <= '0;
            ta_q <= '0;
        end else begin
            if (active) fa_q <= fa_q + ADDR_W'(1);
            if (in_win) ta_q <= ta_q + ADDR_W'(1);
        end
    end

    assign frame_addr = fa_q;
    assign thumb_addr = BASE + ta_q;

    // R10: thumbnail addressing restarts at the region base on each new frame
    a_r10_thumb_base_restart: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (thumb_addr == BASE));

endmodule

// File: rtl/pip_out_stage.sv
module pip_out_stage
    import pip_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  sync_t sync_in,
    input  rgb_t  frame_pix,
    input  rgb_t  thumb_pix,
    input  logic  in_win,
    input  logic  thumb_empty,
    output sync_t sync_out,
    output rgb_t  pix_out,
    output logic  underflow
);

    sync_t sync_q;
    rgb_t  pix_q;
    logic  uf_q;
    logic  use_thumb;
    logic  starve;

    assign use_thumb = in_win && !thumb_empty;
    assign starve    = in_win && thumb_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            pix_q  <= '0;
            uf_q   <= 1'b0;
        end else begin
            sync_q <= sync_in;
            if (!sync_in.de)
                pix_q <= '0;
            else if (use_thumb)
                pix_q <= thumb_pix;
            else
                pix_q <= frame_pix;
            if (starve)
                uf_q <= 1'b1;
        end
    end

    assign sync_out  = sync_q;
    assign pix_out   = pix_q;
    assign underflow = uf_q;

    // R5: strobes leave exactly one cycle after they arrive
    a_r5_sync_delay: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (sync_out == $past(sync_in)));

    // R9: a starved window pixel raises the flag on the next cycle
    a_r9_flag_raise: assert property (@(posedge clk) disable iff (rst)
        (in_win && thumb_empty) |=> underflow);

    // R9: once raised the flag holds until reset
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        underflow |=> underflow);

endmodule

// File: rtl/pip_compositor.sv
module pip_compositor
    import pip_pkg::*;
#(
    parameter int H_ACT      = 1920,
    parameter int V_ACT      = 1080,
    parameter int WIN_X      = 1240,
    parameter int WIN_Y      = 50,
    parameter int WIN_W      = 480,
    parameter int WIN_H      = 270,
    parameter int THUMB_BASE = 2000 * 1080,
    localparam int ADDR_W    = $clog2(THUMB_BASE + WIN_W * WIN_H)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vid_de,
    input  logic              vid_hs,
    input  logic              vid_vs,
    input  logic [23:0]       frame_pix,
    input  logic [23:0]       thumb_pix,
    input  logic              thumb_empty,
    output logic              frame_pop,
    output logic              thumb_pop,
    output logic [ADDR_W-1:0] frame_addr,
    output logic [ADDR_W-1:0] thumb_addr,
    output logic [23:0]       pix_out,
    output logic              de_out,
    output logic              hs_out,
    output logic              vs_out,
    output logic              thumb_underflow
);

    localparam int COL_W  = $clog2(H_ACT + 1);
    localparam int LINE_W = $clog2(V_ACT + 1);

    sync_t             sync_in;
    sync_t             sync_out;
    rgb_t              pix_sel;
    logic              frame_start;
    logic              in_win;
    logic [COL_W-1:0]  col;
    logic [LINE_W-1:0] line;

    assign sync_in = '{de: vid_de, hs: vid_hs, vs: vid_vs};

    pip_pos_tracker #(
        .H_ACT(H_ACT), .V_ACT(V_ACT),
        .WIN_X(WIN_X), .WIN_Y(WIN_Y), .WIN_W(WIN_W), .WIN_H(WIN_H)
    ) u_track (
        .clk(clk), .rst(rst), .sync_in(sync_in),
        .frame_start(frame_start), .col(col), .line(line), .in_win(in_win)
    );

    pip_addr_gen #(
        .ADDR_W(ADDR_W), .THUMB_BASE(THUMB_BASE)
    ) u_addr (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .active(vid_de), .in_win(in_win),
        .frame_addr(frame_addr), .thumb_addr(thumb_addr)
    );

    pip_out_stage u_out (
        .clk(clk), .rst(rst), .sync_in(sync_in),
        .frame_pix(rgb_t'(frame_pix)), .thumb_pix(rgb_t'(thumb_pix)),
        .in_win(in_win), .thumb_empty(thumb_empty),
        .sync_out(sync_out), .pix_out(pix_sel), .underflow(thumb_underflow)
    );

    assign frame_pop = vid_de;
    assign thumb_pop = in_win && !thumb_empty;
    assign pix_out   = pix_sel;
    assign de_out    = sync_out.de;
    assign hs_out    = sync_out.hs;
    assign vs_out    = sync_out.vs;

    // R3: the thumbnail queue is only popped on an active pixel that has data
    a_r3_pop_has_data: assert property (@(posedge clk) disable iff (rst)
        thumb_pop |-> (vid_de && !thumb_empty));

endmodule

// File: tb/pip_compositor_test.sv
`timescale 1ns/1ps
module pip_compositor_test;

    localparam int H  = 16;
    localparam int V  = 6;
    localparam int WX = 10;
    localparam int WY = 2;
    localparam int WW = 4;
    localparam int WH = 2;
    localparam int TB = 200;
    localparam int AW = $clog2(TB + WW * WH);

    typedef struct packed {
        int hblank;
        int empty_idx;
    } scen_t;

    // hblank length per frame, and the thumbnail index that finds the queue empty (-1: none)
    localparam scen_t SCEN [4] = '{
        '{hblank: 2, empty_idx: -1},
        '{hblank: 5, empty_idx: -1},
        '{hblank: 1, empty_idx: 3},
        '{hblank: 3, empty_idx: -1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          vid_de = 1'b0, vid_hs = 1'b0, vid_vs = 1'b0;
    logic [23:0]   frame_pix = '0, thumb_pix = '0;
    logic          thumb_empty = 1'b1;
    logic          frame_pop, thumb_pop;
    logic [AW-1:0] frame_addr, thumb_addr;
    logic [23:0]   pix_out;
    logic          de_out, hs_out, vs_out, thumb_underflow;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    bit pend_ok = 1'b0;
    logic [23:0] exp_pix;
    logic exp_de, exp_hs, exp_vs, exp_uf;
    int tpops;

    always #4 clk = ~clk;

    pip_compositor #(
        .H_ACT(H), .V_ACT(V), .WIN_X(WX), .WIN_Y(WY),
        .WIN_W(WW), .WIN_H(WH), .THUMB_BASE(TB)
    ) uut (
        .clk(clk), .rst(rst), .vid_de(vid_de), .vid_hs(vid_hs), .vid_vs(vid_vs),
        .frame_pix(frame_pix), .thumb_pix(thumb_pix), .thumb_empty(thumb_empty),
        .frame_pop(frame_pop), .thumb_pop(thumb_pop),
        .frame_addr(frame_addr), .thumb_addr(thumb_addr),
        .pix_out(pix_out), .de_out(de_out), .hs_out(hs_out), .vs_out(vs_out),
        .thumb_underflow(thumb_underflow)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_registered();
        check(pix_out == exp_pix, "R4", "pix_out", 32'(pix_out), 32'(exp_pix));
        check(de_out == exp_de, "R5", "de_out", 32'(de_out), 32'(exp_de));
        check(hs_out == exp_hs, "R5", "hs_out", 32'(hs_out), 32'(exp_hs));
        check(vs_out == exp_vs, "R5", "vs_out", 32'(vs_out), 32'(exp_vs));
        check(thumb_underflow == exp_uf, "R9", "thumb_underflow",
              32'(thumb_underflow), 32'(exp_uf));
    endtask

    task automatic step(input bit de, input bit hs, input bit vs,
                        input int line, input int col, input int eidx);
        bit win;
        bit starve;
        int tidx;
        @(negedge clk);
        if (pend_ok) check_registered();
        win    = de && col >= WX && col < WX + WW && line >= WY && line < WY + WH;
        tidx   = win ? (line - WY) * WW + (col - WX) : 0;
        starve = win && (tidx == eidx);
        vid_de = de;
        vid_hs = hs;
        vid_vs = vs;
        frame_pix   = de ? {8'h5A, 8'(line), 8'(col)} : 24'h0;
        thumb_pix   = win ? {8'hC3, 16'(tidx)} : 24'hFFFFFF;
        thumb_empty = win ? starve : 1'b1;
        #1;
        check(frame_pop == de, "R2", "frame_pop", 32'(frame_pop), 32'(de));
        check(thumb_pop == (win && !starve), "R3", "thumb_pop",
              32'(thumb_pop), 32'(win && !starve));
        if (de)
            check(32'(frame_addr) == 32'(line * H + col), "R7 (R6)", "frame_addr",
                  32'(frame_addr), 32'(line * H + col));
        if (win)
            check(32'(thumb_addr) == 32'(TB + tidx), "R8/R10", "thumb_addr",
                  32'(thumb_addr), 32'(TB + tidx));
        if (thumb_pop) tpops++;
        exp_de  = de;
        exp_hs  = hs;
        exp_vs  = vs;
        exp_pix = !de ? 24'h0 : (win && !starve) ? thumb_pix : frame_pix;
        exp_uf  = exp_uf | starve;
        pend_ok = 1'b1;
    endtask

    task automatic run_frame(input int hb, input int eidx);
        tpops = 0;
        step(0, 0, 1, 0, 0, eidx);
        step(0, 0, 1, 0, 0, eidx);
        step(0, 0, 0, 0, 0, eidx);
        for (int l = 0; l < V; l++) begin
            step(0, 1, 0, l, 0, eidx);
            for (int b = 0; b < hb; b++) step(0, 0, 0, l, 0, eidx);
            for (int c = 0; c < H; c++) step(1, 0, 0, l, c, eidx);
            step(0, 0, 0, l, 0, eidx);
            step(0, 0, 0, l, 0, eidx);
        end
        if (eidx < 0)
            check(tpops == WW * WH, "R3", "thumb pops per frame", 32'(tpops), 32'(WW * WH));
        else
            check(tpops == WW * WH - 1, "R9", "thumb pops with one starved pixel",
                  32'(tpops), 32'(WW * WH - 1));
    endtask

    task automatic do_reset();
        pend_ok = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        vid_de = 1'b1; vid_hs = 1'b1; vid_vs = 1'b1;
        frame_pix = 24'hABCDEF;
        thumb_empty = 1'b1;
        repeat (2) @(negedge clk);
        check(pix_out == 24'h0, "R1", "pix_out in reset", 32'(pix_out), 0);
        check({de_out, hs_out, vs_out} == 3'b000, "R1", "strobes in reset",
              32'({de_out, hs_out, vs_out}), 0);
        check(thumb_underflow == 1'b0, "R1", "flag in reset", 32'(thumb_underflow), 0);
        vid_de = 1'b0; vid_hs = 1'b0; vid_vs = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check(pix_out == 24'h0 && de_out == 1'b0 && thumb_underflow == 1'b0, "R1",
              "outputs first cycle after reset", 32'({pix_out, de_out, thumb_underflow}), 0);
        exp_uf = 1'b0;
    endtask

    initial begin
        exp_uf = 1'b0;
        do_reset();
        for (int s = 0; s < 4; s++)
            run_frame(SCEN[s].hblank, SCEN[s].empty_idx);
        // R9: flag stayed latched through the clean final frame
        @(negedge clk);
        check_registered();
        check(thumb_underflow == 1'b1, "R9", "flag sticky after clean frame",
              32'(thumb_underflow), 1);
        do_reset();
        // corner: first-pixel-of-window starvation after reset
        run_frame(4, 0);
        @(negedge clk);
        check_registered();
        do_reset();
        run_frame(2, -1);
        @(negedge clk);
        check_registered();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule